// File: doc/BRIEF.md
# Overlay Control Register and Memory Decoder

This block sits between a host CPU's memory bus and a small expansion memory made of an 8 kB ROM and a RAM cut into 8 kB banks. It holds one write-only control byte, written through an 8-bit I/O port. It combines that byte with a "mapped" flag from an external automapper and with the state of a ROM write-protect jumper. From these it drives the chip selects, the RAM bank number and the write enables for the expansion memories inside the host's 0000h-3FFFh window. Whenever the overlay claims a cycle, it also raises a signal that turns off the host's own ROM.

The control byte holds three fields. The force-map bit overlays the memory unconditionally, which is used for loading or upgrading the system image. The RAM-as-ROM bit is set-only: once set, it makes the top RAM bank stand in for the ROM, write-protected. It is cleared only by power-on reset, so it outlives soft resets. The bank field picks the RAM bank seen at 2000h-3FFFh. The three mapping sources follow a fixed precedence. Force-map ranks highest, RAM-as-ROM comes next, and the jumper ranks lowest.

Top module: `ovl_map_ctrl`

## Requirements
- R1: The control byte is written only on a cycle where `io_wr` is high and `io_addr[7:0]` equals E3h. Bits 15:8 of `io_addr` are ignored. A write to any other port, or with `io_wr` low, leaves the byte unchanged.
- R2: After power-on reset (`por`) every control bit is zero. With the flag mapped and the jumper closed, the decoder then behaves in ROM mode with bank 0.
- R3: Field layout of the written byte. Bit 7 is force-map, bit 6 is RAM-as-ROM, and bits 1:0 are the bank number. Bits 5:2 have no effect.
- R4: A write with bit 6 set sets RAM-as-ROM. A write with bit 6 clear leaves it unchanged. Soft reset does not clear it; only `por` does.
- R5: Soft reset (`srst`) clears force-map and the bank number.
- R6: With force-map set, 0000h-1FFFh selects the ROM. `rom_we` goes high on a write there only if the jumper is open (`rom_jumper_closed` low).
- R7: With force-map set, 2000h-3FFFh selects the chosen bank and is always writable, bank 3 included.
- R8: With force-map clear, RAM-as-ROM set and `mapped` high, 0000h-1FFFh selects RAM bank 3 with `ram_we` held low.
- R9: In the R8 mode, 2000h-3FFFh selects the chosen bank. It is writable unless that bank is 3.
- R10: With force-map and RAM-as-ROM clear, the jumper closed and `mapped` high, 0000h-1FFFh selects the ROM read-only. 2000h-3FFFh selects the chosen bank, which is writable.
- R11: In all other cases every output is low.
- R12: All outputs are low unless `mreq` is high and the address is below 4000h. `host_rom_off` is high exactly when the overlay selects a chip. `rom_cs` and `ram_cs` are never high together. When neither select is high, `ram_bank` is 0.
- R13: Precedence runs from lowest to highest as jumper, then RAM-as-ROM, then force-map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears every bit |
| srst | input | 1 | Soft reset, synchronous, active high, keeps RAM-as-ROM |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address; only bits 7:0 are decoded |
| io_wdata | input | 8 | I/O write data |
| mreq | input | 1 | Memory request active |
| mem_addr | input | 16 | Memory address |
| mem_wr | input | 1 | Memory cycle is a write |
| mapped | input | 1 | Automapper reports the overlay as mapped |
| rom_jumper_closed | input | 1 | ROM write-protect jumper closed |
| rom_cs | output | 1 | Expansion ROM select |
| ram_cs | output | 1 | Expansion RAM select |
| ram_bank | output | 2 | RAM bank number |
| rom_we | output | 1 | ROM write enable |
| ram_we | output | 1 | RAM write enable |
| host_rom_off | output | 1 | Disables the host's internal ROM |

## Verification
The bench attacks the set-only bit in three ways. A write of zero to it, a soft reset and a table of later rows all rely on it staying set. A design that cleared it would fall back to no overlay or to ROM mode. Precedence is probed with all three sources active in different combinations. A decoder with the order wrong would select RAM where ROM is expected, or would let the jumper gate a force-mode ROM write. Bank 3 is written in the upper window both with and without force-map, which exposes a write-protect that is too wide or too narrow. Ports that differ from E3h only in the low byte, E3h with foreign upper bits, writes with the strobe low and bytes with bits 5:2 set each catch a loose port or field decode.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int BANK_W    = 2;
    localparam int CTL_W     = 8;
    localparam int FORCE_BIT = 7;
    localparam int RAMROM_BIT = 6;
    localparam logic [BANK_W-1:0] PROT_BANK = '1;

    typedef struct packed {
        logic              force_map;
        logic              ram_as_rom;
        logic [BANK_W-1:0] bank;
    } ctl_t;

    typedef enum logic [1:0] {
        OVL_NONE,
        OVL_FORCE,
        OVL_RAMROM,
        OVL_ROM
    } ovl_mode_e;

    typedef struct packed {
        logic              rom_cs;
        logic              ram_cs;
        logic [BANK_W-1:0] bank;
        logic              rom_we;
        logic              ram_we;
        logic              host_off;
    } sel_t;

    function automatic ovl_mode_e pick_mode(ctl_t c, logic mapped, logic jumper_closed);
        if (c.force_map)                 return OVL_FORCE;
        else if (mapped && c.ram_as_rom) return OVL_RAMROM;
        else if (mapped && jumper_closed) return OVL_ROM;
        else                             return OVL_NONE;
    endfunction

endpackage

// File: rtl/ovl_port_dec.sv
module ovl_port_dec #(
    parameter int         ADDR_W    = 16,
    parameter logic [7:0] PORT_CODE = 8'hE3
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit
);
    logic unused_hi;
    assign unused_hi = ^io_addr[ADDR_W-1:8];

    always_comb hit = io_wr && (io_addr[7:0] == PORT_CODE);
endmodule

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             srst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             cfg
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[RAMROM_BIT-1:BANK_W];

    always_ff @(posedge clk) begin
        if (por) begin
            cfg <= '0;
        end else begin
            if (srst) begin
                cfg.force_map <= 1'b0;
                cfg.bank      <= '0;
            end else if (wr_en) begin
                cfg.force_map <= wdata[FORCE_BIT];
                cfg.bank      <= wdata[BANK_W-1:0];
                if (wdata[RAMROM_BIT])
                    cfg.ram_as_rom <= 1'b1;
            end
        end
    end

    // R4: once set, RAM-as-ROM stays set until power-on reset
    assert_ramrom_sticky_R4: assert property (@(posedge clk) disable iff (por)
        cfg.ram_as_rom |=> cfg.ram_as_rom);

    // R1: with no port hit and no soft reset the byte holds
    assert_hold_no_hit_R1: assert property (@(posedge clk) disable iff (por)
        (!wr_en && !srst) |=> $stable(cfg));
endmodule

// File: rtl/ovl_map_dec.sv
module ovl_map_dec
    import ovl_pkg::*;
(
    input  logic        clk,
    input  logic        por,
    input  ctl_t        cfg,
    input  logic        mapped,
    input  logic        jumper_closed,
    input  logic        mreq,
    input  logic [15:0] mem_addr,
    input  logic        mem_wr,
    output sel_t        sel
);
    ovl_mode_e mode;
    logic      in_win;
    logic      lo_half;

    always_comb begin
        mode    = pick_mode(cfg, mapped, jumper_closed);
        in_win  = mreq && (mem_addr[15:14] == 2'b00);
        lo_half = !mem_addr[13];
        sel     = '0;
        if (in_win && mode != OVL_NONE) begin
            sel.host_off = 1'b1;
            if (lo_half) begin
                case (mode)
                    OVL_FORCE: begin
                        sel.rom_cs = 1'b1;
                        sel.rom_we = mem_wr && !jumper_closed;
                    end
                    OVL_RAMROM: begin
                        sel.ram_cs = 1'b1;
                        sel.bank   = PROT_BANK;
                    end
                    OVL_ROM: sel.rom_cs = 1'b1;
                    default: ;
                endcase
            end else begin
                sel.ram_cs = 1'b1;
                sel.bank   = cfg.bank;
                sel.ram_we = mem_wr && !(mode == OVL_RAMROM && cfg.bank == PROT_BANK);
            end
        end
    end

    // R12: the two selects never overlap
    assert_cs_exclusive_R12: assert property (@(posedge clk) disable iff (por)
        !(sel.rom_cs && sel.ram_cs));

    // R12: nothing is driven outside an active request in the low window
    assert_outside_idle_R12: assert property (@(posedge clk) disable iff (por)
        !(mreq && mem_addr[15:14] == 2'b00) |-> (sel == '0));

    // R8: the stand-in ROM bank is never written in the low half
    assert_ramrom_ro_R8: assert property (@(posedge clk) disable iff (por)
        (sel.ram_cs && !mem_addr[13]) |-> (!sel.ram_we && sel.bank == PROT_BANK));

    // R6: ROM writes only in force mode with the jumper open
    assert_rom_we_R6: assert property (@(posedge clk) disable iff (por)
        sel.rom_we |-> (cfg.force_map && !jumper_closed && mem_wr));
endmodule

// File: rtl/ovl_map_ctrl.sv
module ovl_map_ctrl
    import ovl_pkg::*;
#(
    parameter logic [7:0] PORT_CODE = 8'hE3
) (
    input  logic              clk,
    input  logic              por,
    input  logic              srst,
    input  logic              io_wr,
    input  logic [15:0]       io_addr,
    input  logic [CTL_W-1:0]  io_wdata,
    input  logic              mreq,
    input  logic [15:0]       mem_addr,
    input  logic              mem_wr,
    input  logic              mapped,
    input  logic              rom_jumper_closed,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic [BANK_W-1:0] ram_bank,
    output logic              rom_we,
    output logic              ram_we,
    output logic              host_rom_off
);
    logic hit;
    ctl_t cfg;
    sel_t sel;

    ovl_port_dec #(.ADDR_W(16), .PORT_CODE(PORT_CODE)) u_port (
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .hit    (hit)
    );

    ovl_ctrl_reg u_reg (
        .clk  (clk),
        .por  (por),
        .srst (srst),
        .wr_en(hit),
        .wdata(io_wdata),
        .cfg  (cfg)
    );

    ovl_map_dec u_dec (
        .clk          (clk),
        .por          (por),
        .cfg          (cfg),
        .mapped       (mapped),
        .jumper_closed(rom_jumper_closed),
        .mreq         (mreq),
        .mem_addr     (mem_addr),
        .mem_wr       (mem_wr),
        .sel          (sel)
    );

    assign rom_cs       = sel.rom_cs;
    assign ram_cs       = sel.ram_cs;
    assign ram_bank     = sel.bank;
    assign rom_we       = sel.rom_we;
    assign ram_we       = sel.ram_we;
    assign host_rom_off = sel.host_off;
endmodule

// File: tb/ovl_map_ctrl_bench.sv
module ovl_map_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        por, srst, io_wr, mreq, mem_wr, mapped, jc;
    logic [15:0] io_addr, mem_addr;
    logic [7:0]  io_wdata;
    logic        rom_cs, ram_cs, rom_we, ram_we, host_rom_off;
    logic [1:0]  ram_bank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    ovl_map_ctrl u_ovl_map_ctrl (
        .clk(clk), .por(por), .srst(srst), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .mreq(mreq), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mapped(mapped), .rom_jumper_closed(jc), .rom_cs(rom_cs), .ram_cs(ram_cs),
        .ram_bank(ram_bank), .rom_we(rom_we), .ram_we(ram_we),
        .host_rom_off(host_rom_off)
    );

    // expected = {rom_cs, ram_cs, ram_bank[1:0], rom_we, ram_we, host_rom_off}
    typedef struct packed {
        logic [7:0]  ctl;
        logic        mp;
        logic        jc;
        logic        mq;
        logic        wr;
        logic [15:0] ad;
        logic [6:0]  ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 7'h00, 4'd11}, // R11 jumper open
        '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 7'h00, 4'd11}, // R11 not mapped
        '{8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0100, 7'h41, 4'd10}, // R10 rom read
        '{8'h02, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0100, 7'h41, 4'd10}, // R10 rom write blocked
        '{8'h02, 1'b1, 1'b1, 1'b1, 1'b1, 16'h2345, 7'h33, 4'd10}, // R10 bank 2 writable
        '{8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0010, 7'h45, 4'd6},  // R6 jumper open
        '{8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0010, 7'h41, 4'd6},  // R6 jumper closed
        '{8'h83, 1'b0, 1'b1, 1'b1, 1'b1, 16'h3000, 7'h3B, 4'd7},  // R7 bank 3 writable
        '{8'h83, 1'b1, 1'b1, 1'b0, 1'b1, 16'h3000, 7'h00, 4'd12}, // R12 no mreq
        '{8'h83, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4000, 7'h00, 4'd12}, // R12 above window
        '{8'h3D, 1'b1, 1'b1, 1'b1, 1'b0, 16'h2000, 7'h29, 4'd3},  // R3 bits 5:2 ignored
        '{8'h41, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 7'h39, 4'd8},  // R8 + R13 over jumper
        '{8'h43, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2000, 7'h39, 4'd9},  // R9 bank 3 protected
        '{8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2000, 7'h33, 4'd4},  // R4 zero write keeps bit
        '{8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 7'h00, 4'd11}, // R11 unmapped
        '{8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 7'h41, 4'd13}, // R13 force over RAM-as-ROM
        '{8'h83, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2000, 7'h3B, 4'd13}  // R13 force lifts protect
    };

    task automatic check(input logic [6:0] exp, input string tag);
        logic [6:0] act;
        act = {rom_cs, ram_cs, ram_bank, rom_we, ram_we, host_rom_off};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic port_wr(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = strobe;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus(input logic mp, input logic j, input logic mq, input logic w,
                       input logic [15:0] a);
        mapped = mp; jc = j; mreq = mq; mem_wr = w; mem_addr = a;
        #1;
    endtask

    task automatic pulse(input bit power);
        @(negedge clk);
        if (power) por = 1'b1; else srst = 1'b1;
        @(negedge clk);
        por = 1'b0; srst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (run) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        por = 1'b1; srst = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
        mreq = 1'b0; mem_wr = 1'b0; mapped = 1'b0; jc = 1'b0; mem_addr = '0;
        repeat (2) @(negedge clk);
        por = 1'b0;

        // R2: zeroed byte, ROM mode with bank 0
        bus(1'b1, 1'b1, 1'b1, 1'b0, 16'h2000);
        check(7'h21, "R2 bank0 after por");
        bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        check(7'h00, "R2 RAM-as-ROM clear");

        for (int i = 0; i < NV; i++) begin
            port_wr(16'h00E3, TBL[i].ctl, 1'b1);
            bus(TBL[i].mp, TBL[i].jc, TBL[i].mq, TBL[i].wr, TBL[i].ad);
            check(TBL[i].ex, $sformatf("R%0d row %0d", TBL[i].rq, i));
        end

        // R1: upper address bits ignored
        port_wr(16'hA5E3, 8'h01, 1'b1);
        bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h2000);
        check(7'h2B, "R1 upper bits ignored");
        // R1: other port ignored
        port_wr(16'h00E7, 8'h83, 1'b1);
        bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h2000);
        check(7'h2B, "R1 foreign port");
        // R1: no strobe, no write
        port_wr(16'h00E3, 8'h83, 1'b0);
        bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h2000);
        check(7'h2B, "R1 strobe low");

        // R5: soft reset clears force and bank, keeps RAM-as-ROM
        port_wr(16'h00E3, 8'h82, 1'b1);
        pulse(1'b0);
        bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h2000);
        check(7'h23, "R5 soft reset bank0");
        bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        check(7'h39, "R4 survives soft reset");

        // R4: power-on clears it
        pulse(1'b1);
        bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        check(7'h00, "R4 cleared by por");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule